// File: doc/BRIEF.md
# Disk Status Wait Poller

This block waits for an attached parallel disk device to become ready before a command or a data burst proceeds. It reaches the device through a small register master port and reads only the alternate status register, so a pending device interrupt is left untouched. A `start` strobe latches the unit number and a mask of wanted status bits. The block then runs two phases. The first waits for the busy bit to drop within an accumulated time budget. The second waits until every masked status bit is set, within a fixed number of evenly spaced polls.

All waiting is counted in pulses of a one-microsecond tick input. In phase one the poll spacing is short while little time has been spent and long after that. A status value of all ones means nobody drives the bus. When that happens the block rewrites the drive-select register for the latched unit, charges one long interval and polls again. When it finishes, the block raises `done` for one cycle and presents a signed result. The result is the status error bit on success, or one of two distinct negative codes for the two timeouts.

Top module: `swp_status_poller`

## Requirements
- R1: Before the first status read of each phase the block waits SETTLE_US ticks of `us_tick`.
- R2: Every read on the master port uses address ALT_ADDR, and an issued request (read or write) holds address and direction until `bus_ack`.
- R3: A phase-one read of 8'hFF writes SEL_BASE | (unit << UNIT_BIT) to address SEL_ADDR, adds SLOW_STEP_US to the elapsed time, waits SLOW_STEP_US ticks, and then continues phase one.
- R4: In phase one a read with bit 7 (busy) set adds FAST_STEP_US to elapsed time and waits that long while elapsed time is at most FAST_LIMIT_US; otherwise it adds and waits SLOW_STEP_US.
- R5: When the elapsed time has reached BUSY_BUDGET_US at the point a phase-one poll would be made, the block ends with result 4'b1110 (-2).
- R6: With a zero mask, the first phase-one read with bit 7 clear ends the run with result equal to status bit 0 (error), zero-extended.
- R7: With a nonzero mask, phase two reads up to BIT_POLLS times, BIT_STEP_US ticks apart. The first read with all mask bits set ends the run with result equal to its bit 0.
- R8: If none of the BIT_POLLS phase-two reads match, the block ends after the last interval with result 4'b1101 (-3).
- R9: `done` is high for exactly one cycle, with `result` valid and `busy` low in that cycle. Unit and mask are taken only at the accepted `start`.
- R10: A `start` while `busy` is high has no effect on the running poll, its result, or the number of `done` pulses.
- R11: After reset `busy`, `done`, `bus_req` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| start | input | 1 | Begin a wait (ignored while busy) |
| unit | input | UNIT_W | Device unit to reselect on a floating bus |
| mask | input | 8 | Status bits that must all be set in phase two |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 4 | Signed result: 0/1 error bit, -2 busy timeout, -3 bit timeout |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 8 | Read data |

## Verification
The bench feeds scripted status sequences and checks the poll count, the reselect writes, the result and the ticks spent against a reference walk of the two phases. It targets the change from short to long spacing exactly at the fast limit, since a design that switches one poll early or late makes a different number of reads before the -2 result. It also targets a bus that floats forever, where a design that does not charge the penalty never times out, and a phase-two match on the very last allowed poll, where an off-by-one poll counter would return -3. A second start during a long busy wait, with a different mask and unit on the pins, must leave the result and the done count unchanged.

// File: rtl/swp_pkg.sv
package swp_pkg;

   localparam int STAT_W = 8;
   localparam int RES_W  = 4;

   localparam int BUSY_BIT = 7;
   localparam int ERR_BIT  = 0;
   localparam logic [STAT_W-1:0] FLOAT_STAT = 8'hFF;

   localparam logic [RES_W-1:0] RC_BUSY_TIMEOUT = 4'b1110;
   localparam logic [RES_W-1:0] RC_BITS_TIMEOUT = 4'b1101;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE1,
      ST_READ1,
      ST_RESEL,
      ST_GAP1,
      ST_SETTLE2,
      ST_READ2,
      ST_GAP2
   } swp_state_t;

endpackage

// File: rtl/swp_tick_delay.sv
module swp_tick_delay #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   input  logic             tick,
   output logic             fin
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= len;
         run_q <= 1'b1;
      end else if (run_q && tick) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            run_q <= 1'b0;
         end
      end
   end

   assign fin = run_q && tick && (cnt_q == CNT_W'(1)) && !load;

endmodule

// File: rtl/swp_bus_master.sv
module swp_bus_master #(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter bit CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              issue_we,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [DATA_W-1:0] issue_wdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              xfer_done,
   output logic [DATA_W-1:0] xfer_rdata
);

   logic              req_q;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (issue) begin
         req_q   <= 1'b1;
         we_q    <= issue_we;
         addr_q  <= issue_addr;
         wdata_q <= issue_wdata;
      end else if (req_q && bus_ack) begin
         req_q <= 1'b0;
      end
   end

   assign hit       = req_q && bus_ack;
   assign bus_req   = req_q;
   assign bus_we    = we_q;
   assign bus_addr  = addr_q;
   assign bus_wdata = wdata_q;

   generate
      if (CAPTURE) begin : g_capture
         logic              done_q;
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               done_q <= 1'b0;
               data_q <= '0;
            end else begin
               done_q <= hit;
               if (hit) begin
                  data_q <= bus_rdata;
               end
            end
         end
         assign xfer_done  = done_q;
         assign xfer_rdata = data_q;
      end else begin : g_direct
         assign xfer_done  = hit;
         assign xfer_rdata = bus_rdata;
      end
   endgenerate

endmodule

// File: rtl/swp_status_poller.sv
module swp_status_poller
   import swp_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int ALT_ADDR       = 14,
   parameter int SEL_ADDR       = 6,
   parameter int SEL_BASE       = 8'hA0,
   parameter int UNIT_W         = 1,
   parameter int UNIT_BIT       = 4,
   parameter int SETTLE_US      = 1,
   parameter int BUSY_BUDGET_US = 1000000,
   parameter int FAST_LIMIT_US  = 1000,
   parameter int FAST_STEP_US   = 10,
   parameter int SLOW_STEP_US   = 1000,
   parameter int BIT_POLLS      = 5000,
   parameter int BIT_STEP_US    = 10,
   parameter bit CAPTURE_RDATA  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    us_tick,
   input  logic                    start,
   input  logic [UNIT_W-1:0]       unit,
   input  logic [STAT_W-1:0]       mask,
   output logic                    busy,
   output logic                    done,
   output logic signed [RES_W-1:0] result,
   output logic                    bus_req,
   output logic                    bus_we,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [STAT_W-1:0]       bus_wdata,
   input  logic                    bus_ack,
   input  logic [STAT_W-1:0]       bus_rdata
);

   localparam int EL_W     = $clog2(BUSY_BUDGET_US + SLOW_STEP_US + 1);
   localparam int STEP_A   = (FAST_STEP_US > SLOW_STEP_US) ? FAST_STEP_US : SLOW_STEP_US;
   localparam int STEP_B   = (SETTLE_US > BIT_STEP_US) ? SETTLE_US : BIT_STEP_US;
   localparam int MAX_STEP = (STEP_A > STEP_B) ? STEP_A : STEP_B;
   localparam int DLY_W    = $clog2(MAX_STEP + 1);
   localparam int PC_W     = $clog2(BIT_POLLS + 1);

   generate
      if (SETTLE_US < 1 || FAST_STEP_US < 1 || SLOW_STEP_US < 1 || BIT_STEP_US < 1) begin : g_bad_step
         $error("swp_status_poller: every delay step must be at least one tick");
      end
      if (BIT_POLLS < 1 || BUSY_BUDGET_US < 1) begin : g_bad_budget
         $error("swp_status_poller: budgets must be nonzero");
      end
      if (FAST_LIMIT_US >= BUSY_BUDGET_US) begin : g_bad_limit
         $error("swp_status_poller: fast limit must lie below the busy budget");
      end
      if (UNIT_W + UNIT_BIT > STAT_W || ALT_ADDR >= (1 << ADDR_W) || SEL_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("swp_status_poller: unit field or addresses do not fit");
      end
   endgenerate

   swp_state_t               state_q, state_d;
   logic [UNIT_W-1:0]        unit_q;
   logic [STAT_W-1:0]        mask_q;
   logic [EL_W-1:0]          elapsed_q, elapsed_d;
   logic [PC_W-1:0]          polls_q, polls_d;
   logic                     done_q;
   logic signed [RES_W-1:0]  result_q;

   logic                     issue, issue_we;
   logic [ADDR_W-1:0]        issue_addr;
   logic [STAT_W-1:0]        sel_value;
   logic                     xfer_done;
   logic [STAT_W-1:0]        xfer_rdata;
   logic                     dly_load, dly_fin;
   logic [DLY_W-1:0]         dly_len;
   logic                     finish;
   logic [RES_W-1:0]         finish_code;
   logic                     accept;

   assign accept    = (state_q == ST_IDLE) && start;
   assign sel_value = STAT_W'(SEL_BASE) | (STAT_W'(unit_q) << UNIT_BIT);

   swp_tick_delay #(.CNT_W(DLY_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (dly_load),
      .len   (dly_len),
      .tick  (us_tick),
      .fin   (dly_fin)
   );

   swp_bus_master #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (STAT_W),
      .CAPTURE (CAPTURE_RDATA)
   ) u_bus (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue       (issue),
      .issue_we    (issue_we),
      .issue_addr  (issue_addr),
      .issue_wdata (sel_value),
      .bus_req     (bus_req),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_ack     (bus_ack),
      .bus_rdata   (bus_rdata),
      .xfer_done   (xfer_done),
      .xfer_rdata  (xfer_rdata)
   );

   always_comb begin
      state_d     = state_q;
      issue       = 1'b0;
      issue_we    = 1'b0;
      issue_addr  = ADDR_W'(ALT_ADDR);
      dly_load    = 1'b0;
      dly_len     = DLY_W'(SETTLE_US);
      elapsed_d   = elapsed_q;
      polls_d     = polls_q;
      finish      = 1'b0;
      finish_code = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               state_d   = ST_SETTLE1;
               dly_load  = 1'b1;
               dly_len   = DLY_W'(SETTLE_US);
               elapsed_d = '0;
               polls_d   = '0;
            end
         end
         ST_SETTLE1: begin
            if (dly_fin) begin
               issue   = 1'b1;
               state_d = ST_READ1;
            end
         end
         ST_READ1: begin
            if (xfer_done) begin
               if (xfer_rdata == FLOAT_STAT) begin
                  issue      = 1'b1;
                  issue_we   = 1'b1;
                  issue_addr = ADDR_W'(SEL_ADDR);
                  elapsed_d  = elapsed_q + EL_W'(SLOW_STEP_US);
                  state_d    = ST_RESEL;
               end else if (!xfer_rdata[BUSY_BIT]) begin
                  if (mask_q == '0) begin
                     finish      = 1'b1;
                     finish_code = RES_W'(xfer_rdata[ERR_BIT]);
                  end else begin
                     dly_load = 1'b1;
                     dly_len  = DLY_W'(SETTLE_US);
                     state_d  = ST_SETTLE2;
                  end
               end else begin
                  dly_load = 1'b1;
                  state_d  = ST_GAP1;
                  if (elapsed_q > EL_W'(FAST_LIMIT_US)) begin
                     elapsed_d = elapsed_q + EL_W'(SLOW_STEP_US);
                     dly_len   = DLY_W'(SLOW_STEP_US);
                  end else begin
                     elapsed_d = elapsed_q + EL_W'(FAST_STEP_US);
                     dly_len   = DLY_W'(FAST_STEP_US);
                  end
               end
            end
         end
         ST_RESEL: begin
            if (xfer_done) begin
               dly_load = 1'b1;
               dly_len  = DLY_W'(SLOW_STEP_US);
               state_d  = ST_GAP1;
            end
         end
         ST_GAP1: begin
            if (dly_fin) begin
               if (elapsed_q >= EL_W'(BUSY_BUDGET_US)) begin
                  finish      = 1'b1;
                  finish_code = RC_BUSY_TIMEOUT;
               end else begin
                  issue   = 1'b1;
                  state_d = ST_READ1;
               end
            end
         end
         ST_SETTLE2: begin
            if (dly_fin) begin
               issue   = 1'b1;
               state_d = ST_READ2;
            end
         end
         ST_READ2: begin
            if (xfer_done) begin
               if ((xfer_rdata & mask_q) == mask_q) begin
                  finish      = 1'b1;
                  finish_code = RES_W'(xfer_rdata[ERR_BIT]);
               end else begin
                  polls_d  = polls_q + 1'b1;
                  dly_load = 1'b1;
                  dly_len  = DLY_W'(BIT_STEP_US);
                  state_d  = ST_GAP2;
               end
            end
         end
         ST_GAP2: begin
            if (dly_fin) begin
               if (polls_q >= PC_W'(BIT_POLLS)) begin
                  finish      = 1'b1;
                  finish_code = RC_BITS_TIMEOUT;
               end else begin
                  issue   = 1'b1;
                  state_d = ST_READ2;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (finish) begin
         state_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         unit_q    <= '0;
         mask_q    <= '0;
         elapsed_q <= '0;
         polls_q   <= '0;
         done_q    <= 1'b0;
         result_q  <= '0;
      end else begin
         state_q   <= state_d;
         elapsed_q <= elapsed_d;
         polls_q   <= polls_d;
         done_q    <= finish;
         if (accept) begin
            unit_q <= unit;
            mask_q <= mask;
         end
         if (finish) begin
            result_q <= finish_code;
         end
      end
   end

   assign busy   = (state_q != ST_IDLE);
   assign done   = done_q;
   assign result = result_q;

endmodule

// File: rtl/swp_status_poller_chk.sv
module swp_status_poller_chk #(
   parameter int ADDR_W   = 4,
   parameter int ALT_ADDR = 14,
   parameter int SEL_ADDR = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [3:0]        result,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ack
);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R5
   result_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result == 4'b0000 || result == 4'b0001 ||
                result == 4'b1110 || result == 4'b1101));

   // R2
   read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |-> (bus_addr == ADDR_W'(ALT_ADDR)));

   // R3
   resel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> (bus_addr == ADDR_W'(SEL_ADDR)));

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !bus_req) |=> !done || busy == 1'b0);

endmodule

bind swp_status_poller swp_status_poller_chk #(
   .ADDR_W   (ADDR_W),
   .ALT_ADDR (ALT_ADDR),
   .SEL_ADDR (SEL_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .result   (result),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_ack  (bus_ack)
);

// File: tb/swp_status_poller_test.sv
module swp_status_poller_test;

   localparam int P_SETTLE = 1;
   localparam int P_BUDGET = 60;
   localparam int P_FLIM   = 10;
   localparam int P_FAST   = 2;
   localparam int P_SLOW   = 8;
   localparam int P_POLLS  = 4;
   localparam int P_BSTEP  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       us_tick = 1'b0;
   logic       start = 1'b0;
   logic [0:0] unit = '0;
   logic [7:0] mask = '0;
   logic       busy, done;
   logic signed [3:0] result;
   logic       bus_req, bus_we;
   logic [3:0] bus_addr;
   logic [7:0] bus_wdata;
   logic       bus_ack = 1'b0;
   logic [7:0] bus_rdata = '0;

   swp_status_poller #(
      .SETTLE_US      (P_SETTLE),
      .BUSY_BUDGET_US (P_BUDGET),
      .FAST_LIMIT_US  (P_FLIM),
      .FAST_STEP_US   (P_FAST),
      .SLOW_STEP_US   (P_SLOW),
      .BIT_POLLS      (P_POLLS),
      .BIT_STEP_US    (P_BSTEP),
      .CAPTURE_RDATA  (1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .unit(unit),
      .mask(mask), .busy(busy), .done(done), .result(result),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0, sel_cnt = 0, tick_cnt = 0, done_seen = 0;
   int addr_bad = 0, wdata_bad = 0;
   logic [7:0] exp_wdata = 8'hA0;
   logic [7:0] scr [0:31];
   int scr_len = 0, scr_idx = 0;

   logic [3:0] q_res [$];
   int         q_rd [$];
   int         q_sel [$];
   int         q_ws [$];
   string      q_tag [$];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input string what, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d..%0d", tag, what, act, lo, hi);
      end
   endtask

   function automatic logic [7:0] peek(input int i);
      return scr[(i < scr_len) ? i : scr_len - 1];
   endfunction

   task automatic scr_clear();
      scr_len = 0;
   endtask

   task automatic scr_add(input int n, input logic [7:0] v);
      for (int i = 0; i < n; i++) begin
         scr[scr_len] = v;
         scr_len++;
      end
   endtask

   // reference walk of both phases from the requirements
   task automatic model(input logic [7:0] msk, output logic [3:0] res,
                        output int rd, output int sl, output int ws);
      int el;
      int idx;
      logic [7:0] st;
      bit left;
      el = 0; idx = 0; rd = 0; sl = 0; ws = P_SETTLE; st = 8'h00; left = 1'b0;
      res = 4'b0000;
      while (!left) begin
         if (el >= P_BUDGET) begin
            res = 4'b1110;
            return;
         end
         st = peek(idx); idx++; rd++;
         if (st == 8'hFF) begin
            sl++; el += P_SLOW; ws += P_SLOW;
         end else if (!st[7]) begin
            left = 1'b1;
         end else if (el > P_FLIM) begin
            el += P_SLOW; ws += P_SLOW;
         end else begin
            el += P_FAST; ws += P_FAST;
         end
      end
      if (msk == 8'h00) begin
         res = {3'b000, st[0]};
         return;
      end
      ws += P_SETTLE;
      for (int k = 0; k < P_POLLS; k++) begin
         st = peek(idx); idx++; rd++;
         if ((st & msk) == msk) begin
            res = {3'b000, st[0]};
            return;
         end
         ws += P_BSTEP;
      end
      res = 4'b1101;
   endtask

   // driver: predicts, pushes, starts and waits for the monitor
   task automatic run_case(input string tag, input logic [7:0] msk, input logic un, input bit intrude);
      logic [3:0] r;
      int rd, sl, ws, target;
      model(msk, r, rd, sl, ws);
      q_res.push_back(r); q_rd.push_back(rd); q_sel.push_back(sl);
      q_ws.push_back(ws); q_tag.push_back(tag);
      @(negedge clk);
      rd_cnt = 0; sel_cnt = 0; scr_idx = 0; addr_bad = 0; wdata_bad = 0;
      exp_wdata = 8'hA0 | (8'(un) << 4);
      mask = msk; unit = un; start = 1'b1; tick_cnt = 0;
      target = done_seen + 1;
      @(negedge clk);
      start = 1'b0;
      if (intrude) begin
         repeat (20) @(negedge clk);
         mask = 8'h01; unit = ~un; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (done_seen < target) @(negedge clk);
      chk(tag, "R2 read address errors", addr_bad, 0);
      chk(tag, "R3 reselect data errors", wdata_bad, 0);
   endtask

   // device model
   initial begin
      forever begin
         @(negedge clk);
         if (bus_req && !bus_ack) begin
            bus_ack = 1'b1;
            if (bus_we) begin
               sel_cnt++;
               if (bus_wdata != exp_wdata || bus_addr != 4'd6) wdata_bad++;
            end else begin
               rd_cnt++;
               if (bus_addr != 4'd14) addr_bad++;
               bus_rdata = peek(scr_idx);
               scr_idx++;
            end
         end else begin
            bus_ack = 1'b0;
         end
      end
   end

   // microsecond tick, one pulse every three clocks
   initial begin
      forever begin
         repeat (2) @(negedge clk);
         us_tick = 1'b1;
         tick_cnt++;
         @(negedge clk);
         us_tick = 1'b0;
      end
   end

   // monitor: pops predictions as results appear
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            done_seen++;
            if (q_res.size() == 0) begin
               checks++; errors++;
               $display("FAIL R10 unexpected done actual 1 expected 0");
            end else begin
               automatic string t = q_tag.pop_front();
               automatic logic [3:0] er = q_res.pop_front();
               automatic int erd = q_rd.pop_front();
               automatic int esl = q_sel.pop_front();
               automatic int ews = q_ws.pop_front();
               chk(t, "result", int'(result[3:0]), int'(er));
               chk(t, "R4 status reads", rd_cnt, erd);
               chk(t, "R3 reselect writes", sel_cnt, esl);
               chk_rng(t, "R1/R4 ticks spent", tick_cnt, ews, ews + 2 * (erd + esl) + 3);
               chk(t, "R9 busy low at done", int'(busy), 0);
               @(negedge clk);
               chk(t, "R9 done width", int'(done), 0);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog done count actual %0d expected completion", done_seen);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R11", "busy after reset", int'(busy), 0);
      chk("R11", "done after reset", int'(done), 0);
      chk("R11", "bus_req after reset", int'(bus_req), 0);
      chk("R11", "result after reset", int'(result), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      scr_clear(); scr_add(1, 8'h51);
      run_case("R6 error set", 8'h00, 1'b0, 1'b0);
      scr_clear(); scr_add(1, 8'h50);
      run_case("R6 error clear", 8'h00, 1'b0, 1'b0);
      scr_clear(); scr_add(3, 8'h80); scr_add(1, 8'h58);
      run_case("R7 busy then bits", 8'h48, 1'b0, 1'b0);
      scr_clear(); scr_add(6, 8'h80); scr_add(1, 8'h80); scr_add(1, 8'h40);
      run_case("R4 clears after slow poll", 8'h00, 1'b0, 1'b0);
      scr_clear(); scr_add(1, 8'h80);
      run_case("R5 busy forever", 8'h00, 1'b0, 1'b0);
      scr_clear(); scr_add(2, 8'hFF); scr_add(1, 8'h50);
      run_case("R3 float then ready unit1", 8'h00, 1'b1, 1'b0);
      scr_clear(); scr_add(1, 8'hFF);
      run_case("R3 float forever", 8'h00, 1'b0, 1'b0);
      scr_clear(); scr_add(1, 8'h50);
      run_case("R8 bits never set", 8'h08, 1'b0, 1'b0);
      scr_clear(); scr_add(3, 8'h50); scr_add(1, 8'h59);
      run_case("R7 match third poll", 8'h09, 1'b0, 1'b0);
      scr_clear(); scr_add(4, 8'h50); scr_add(1, 8'h5C);
      run_case("R7 match last poll", 8'h0C, 1'b0, 1'b0);
      scr_clear(); scr_add(1, 8'h80);
      run_case("R10 start while busy", 8'h00, 1'b0, 1'b1);
      begin
         automatic int seen = done_seen;
         repeat (40) @(negedge clk);
         chk("R10", "extra done pulses", done_seen - seen, 0);
         chk("R10", "busy after ignored start", int'(busy), 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule